// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the slave-side front end of a byte-wide nonvolatile memory with a 15-bit address space. The SPI pins (serial clock, active-low select, serial in) are brought into a faster system clock through synchronizers, and clock edges are detected there. Bits are captured on rising serial-clock edges and driven out on falling ones. Either clock polarity works: the idle level seen while deselected is taken as the polarity.

The first byte of every selection is an opcode. Memory commands then take a two-byte address and either stream bytes out of a registered parallel read port or commit incoming bytes to a parallel write port. The address moves forward after each byte and wraps at the top of the space. The engine also returns a fixed 32-bit identity word and the status byte.

Write permission, the write-enable latch and the stored status byte belong to a separate protection block. This engine asks it for a grant, sends it set and clear pulses for the latch, and hands it new status contents.

Top module: `spi_mem_engine`

## Requirements
- R1: Bytes are shifted most significant bit first. Opcode 0x06 produces one `wel_set` pulse and opcode 0x04 produces one `wel_clr` pulse.
- R2: If select rises before the eighth opcode bit has been sampled, nothing executes. There is no latch pulse and no memory or status access.
- R3: Memory commands take a 16-bit address, high byte first. Bit 15 is ignored and bits 14:0 pick the byte.
- R4: Opcode 0x03 returns the byte at the address on the first 8 clocks after the address, and the next address on each further 8 clocks. The data is driven on falling edges. After 0x7FFF the address wraps to 0x0000.
- R5: Opcode 0x0B behaves like 0x03, except that 8 dummy clocks follow the address before the first data bit, and SO stays high-impedance during them.
- R6: Opcode 0x02 commits each complete byte after the address to the current address through `mem_wr`, but only while `wr_grant` is high for that address. A byte without a grant is dropped. The address then advances and wraps after 0x7FFF.
- R7: Opcode 0x05 outputs `stat_in` and repeats it for every further 8 clocks.
- R8: Opcode 0x9F outputs 0x04, 0x7F, 0x05, 0x09. After the 32nd bit, SO holds the last bit (1) for any further clocks.
- R9: SO is high-impedance while deselected and during the opcode and address phases. Values on SI during data output have no effect on the output.
- R10: Opcode 0x01 takes one byte. If `stat_grant` is high, it issues `stat_wr` with bits 7:2 of that byte and bits 1:0 forced to zero. Further bytes in the same selection are ignored.
- R11: When select rises after a recognised 0x02 or 0x01 opcode, one `wel_clr` pulse is produced.
- R12: Any other opcode leaves the engine idle until select rises: SO stays high-impedance and there is no access or pulse.
- R13: All of the above hold with the clock idling low (mode 0) and with the clock idling high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low select |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out value |
| spi_so_oe | output | 1 | Output enable for SO; low means high-impedance |
| mem_addr | output | 15 | Current memory address |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` one cycle later |
| mem_rdata | input | 8 | Read data from the array |
| mem_wr | output | 1 | Write strobe for `mem_addr` |
| mem_wdata | output | 8 | Write data |
| wr_grant | input | 1 | Protection grant for a write to `mem_addr` |
| stat_in | input | 8 | Current status byte |
| stat_grant | input | 1 | Protection grant for a status write |
| stat_wr | output | 1 | Status write strobe |
| stat_wdata | output | 8 | New status byte, bits 1:0 zero |
| wel_set | output | 1 | Pulse that sets the write-enable latch |
| wel_clr | output | 1 | Pulse that clears the write-enable latch |

## Verification
The assertions watch, on every cycle, that SO is disabled after deselection and in the opcode phase, that no strobe fires while an opcode is still being collected, and that every memory or status write follows a grant. They also check that the write address moves up by one, with wrap, after each write. Only the bench scenarios can show the byte-level behaviour: the opcode values, the address assembly and the ignored top bit, the dummy gap, the identity word with its held bit, repeated status reads, dropped writes, and identical results in both clock polarities.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    typedef enum logic [3:0] {
        ST_OPC,
        ST_ADDR,
        ST_DUMMY,
        ST_RDATA,
        ST_WDATA,
        ST_WSR,
        ST_STAT,
        ST_ID,
        ST_IDLE
    } eng_state_t;

    localparam logic [7:0] OP_LATCH_ON  = 8'h06;
    localparam logic [7:0] OP_LATCH_OFF = 8'h04;
    localparam logic [7:0] OP_STAT_GET  = 8'h05;
    localparam logic [7:0] OP_STAT_PUT  = 8'h01;
    localparam logic [7:0] OP_MEM_GET   = 8'h03;
    localparam logic [7:0] OP_MEM_PUT   = 8'h02;
    localparam logic [7:0] OP_IDENT     = 8'h9F;
    localparam logic [7:0] OP_MEM_FAST  = 8'h0B;

    localparam logic [31:0] IDENT_WORD  = 32'h047F_0509;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic csn_in,
    input  logic si_in,
    output logic sck_lvl,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic cs_end,
    output logic si_lvl
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] csn;
        logic [STAGES-1:0] si;
        logic              sck_prev;
        logic              csn_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.sck      = {q.sck[STAGES-2:0], sck_in};
        d.csn      = {q.csn[STAGES-2:0], csn_in};
        d.si       = {q.si[STAGES-2:0], si_in};
        d.sck_prev = q.sck[LAST];
        d.csn_prev = q.csn[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.csn      <= '1;
            q.csn_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sck_lvl  = q.sck[LAST];
    assign sck_rise = q.sck[LAST] & ~q.sck_prev;
    assign sck_fall = ~q.sck[LAST] & q.sck_prev;
    assign cs_act   = ~q.csn[LAST];
    assign cs_end   = q.csn[LAST] & ~q.csn_prev;
    assign si_lvl   = q.si[LAST];

endmodule

// File: rtl/spi_mem_cmd.sv
module spi_mem_cmd
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter logic [31:0] ID_WORD = IDENT_WORD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_lvl,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_act,
    input  logic              cs_end,
    input  logic              si_lvl,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic              wr_grant,
    input  logic [7:0]        stat_in,
    input  logic              stat_grant,
    output logic              stat_wr,
    output logic [7:0]        stat_wdata,
    output logic              wel_set,
    output logic              wel_clr
);
    localparam int HI_W = ADDR_W - 8;

    typedef struct packed {
        eng_state_t        st;
        logic [2:0]        bit_idx;
        logic              addr_lo;
        logic [6:0]        sh;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       tx;
        logic              so;
        logic              oe;
        logic              fast;
        logic              wr_cmd;
        logic              cpol;
        logic              rise_seen;
        logic              mem_rd;
        logic              mem_wr;
        logic [7:0]        wdata;
        logic              load;
        logic              adv;
        logic              st_wr;
        logic [7:0]        st_wdata;
        logic              wel_set;
        logic              wel_clr;
    } eng_t;

    eng_t q, d;
    logic [7:0] rx_byte;
    logic       out_phase;

    assign rx_byte   = {q.sh, si_lvl};
    assign out_phase = (q.st == ST_RDATA) || (q.st == ST_STAT) || (q.st == ST_ID);

    always_comb begin
        d         = q;
        d.mem_rd  = 1'b0;
        d.mem_wr  = 1'b0;
        d.st_wr   = 1'b0;
        d.wel_set = 1'b0;
        d.wel_clr = 1'b0;
        d.adv     = 1'b0;
        d.load    = q.mem_rd;
        if (q.load) d.tx = {mem_rdata, 24'h0};
        if (q.adv)  d.addr = q.addr + 1'b1;

        if (!cs_act) begin
            d.st        = ST_OPC;
            d.bit_idx   = '0;
            d.addr_lo   = 1'b0;
            d.oe        = 1'b0;
            d.fast      = 1'b0;
            d.wr_cmd    = 1'b0;
            d.rise_seen = 1'b0;
            d.load      = 1'b0;
            d.cpol      = sck_lvl;
            if (cs_end && q.wr_cmd) d.wel_clr = 1'b1;
        end else if (sck_rise) begin
            d.rise_seen = 1'b1;
            d.sh        = rx_byte[6:0];
            d.bit_idx   = q.bit_idx + 1'b1;
            if (q.bit_idx == 3'd7) begin
                case (q.st)
                    ST_OPC: begin
                        case (rx_byte)
                            OP_LATCH_ON:  begin d.wel_set = 1'b1; d.st = ST_IDLE; end
                            OP_LATCH_OFF: begin d.wel_clr = 1'b1; d.st = ST_IDLE; end
                            OP_STAT_GET:  begin d.tx = {stat_in, 24'h0}; d.st = ST_STAT; end
                            OP_STAT_PUT:  begin d.wr_cmd = 1'b1; d.st = ST_WSR; end
                            OP_MEM_GET:   d.st = ST_ADDR;
                            OP_MEM_FAST:  begin d.fast = 1'b1; d.st = ST_ADDR; end
                            OP_MEM_PUT:   begin d.wr_cmd = 1'b1; d.st = ST_ADDR; end
                            OP_IDENT:     begin d.tx = ID_WORD; d.st = ST_ID; end
                            default:      d.st = ST_IDLE;
                        endcase
                    end
                    ST_ADDR: begin
                        if (!q.addr_lo) begin
                            d.addr    = {rx_byte[HI_W-1:0], q.addr[7:0]};
                            d.addr_lo = 1'b1;
                        end else begin
                            d.addr = {q.addr[ADDR_W-1:8], rx_byte};
                            if (q.wr_cmd) begin
                                d.st = ST_WDATA;
                            end else if (q.fast) begin
                                d.st = ST_DUMMY;
                            end else begin
                                d.st     = ST_RDATA;
                                d.mem_rd = 1'b1;
                            end
                        end
                    end
                    ST_DUMMY: begin
                        d.st     = ST_RDATA;
                        d.mem_rd = 1'b1;
                    end
                    ST_RDATA: begin
                        d.addr   = q.addr + 1'b1;
                        d.mem_rd = 1'b1;
                    end
                    ST_WDATA: begin
                        d.mem_wr = wr_grant;
                        d.wdata  = rx_byte;
                        d.adv    = 1'b1;
                    end
                    ST_WSR: begin
                        d.st_wr    = stat_grant;
                        d.st_wdata = {rx_byte[7:2], 2'b00};
                        d.st       = ST_IDLE;
                    end
                    ST_STAT: d.tx = {stat_in, 24'h0};
                    default: ;
                endcase
            end
        end else if (sck_fall && (q.rise_seen || !q.cpol)) begin
            if (out_phase) begin
                d.oe = 1'b1;
                d.so = q.tx[31];
                d.tx = {q.tx[30:0], q.tx[0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign so         = q.so;
    assign so_oe      = q.oe;
    assign mem_addr   = q.addr;
    assign mem_rd     = q.mem_rd;
    assign mem_wr     = q.mem_wr;
    assign mem_wdata  = q.wdata;
    assign stat_wr    = q.st_wr;
    assign stat_wdata = q.st_wdata;
    assign wel_set    = q.wel_set;
    assign wel_clr    = q.wel_clr;

    assert_hiz_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !so_oe);
    assert_hiz_opcode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_OPC) |-> !so_oe);
    assert_no_access_in_opcode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_OPC) |-> !(mem_wr || mem_rd || stat_wr || wel_set));
    assert_wr_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(wr_grant));
    assert_wr_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (mem_addr == $past(mem_addr) + 1'b1));
    assert_stat_granted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |-> $past(stat_grant));

endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic              wr_grant,
    input  logic [7:0]        stat_in,
    input  logic              stat_grant,
    output logic              stat_wr,
    output logic [7:0]        stat_wdata,
    output logic              wel_set,
    output logic              wel_clr
);
    logic sck_lvl, sck_rise, sck_fall, cs_act, cs_end, si_lvl;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_in   (spi_sck),
        .csn_in   (spi_cs_n),
        .si_in    (spi_si),
        .sck_lvl  (sck_lvl),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_act   (cs_act),
        .cs_end   (cs_end),
        .si_lvl   (si_lvl)
    );

    spi_mem_cmd #(.ADDR_W(ADDR_W), .ID_WORD(IDENT_WORD)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_lvl    (sck_lvl),
        .sck_rise   (sck_rise),
        .sck_fall   (sck_fall),
        .cs_act     (cs_act),
        .cs_end     (cs_end),
        .si_lvl     (si_lvl),
        .so         (spi_so),
        .so_oe      (spi_so_oe),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_rdata  (mem_rdata),
        .mem_wr     (mem_wr),
        .mem_wdata  (mem_wdata),
        .wr_grant   (wr_grant),
        .stat_in    (stat_in),
        .stat_grant (stat_grant),
        .stat_wr    (stat_wr),
        .stat_wdata (stat_wdata),
        .wel_set    (wel_set),
        .wel_clr    (wel_clr)
    );

endmodule

// File: tb/sim_spi_mem_engine.sv
module sim_spi_mem_engine;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0;
    logic spi_so, spi_so_oe;
    logic [14:0] mem_addr;
    logic mem_rd, mem_wr, stat_wr, wel_set, wel_clr;
    logic [7:0] mem_rdata = 8'h0, mem_wdata, stat_wdata;
    logic [7:0] stat_in = 8'h0;
    logic stat_grant = 1'b0;
    logic [15:0] wlim = 16'h8000;
    logic wr_grant;

    int nchk = 0, nfail = 0, mode = 0;
    bit done = 0;
    int n_set = 0, n_clr = 0, n_wr = 0, n_rd = 0, n_st = 0;
    logic [14:0] wl_a [8];
    logic [7:0]  wl_d [8];
    logic [7:0]  last_st = 8'h0;
    logic [7:0]  rx;
    bit oe_any, oe_all;

    always #2 clk = ~clk;

    assign wr_grant = ({1'b0, mem_addr} < wlim);

    spi_mem_engine u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_si(spi_si),
        .spi_so(spi_so), .spi_so_oe(spi_so_oe), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .wr_grant(wr_grant),
        .stat_in(stat_in), .stat_grant(stat_grant), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .wel_set(wel_set), .wel_clr(wel_clr)
    );

    function automatic logic [7:0] pat(input logic [14:0] a);
        return (a[7:0] ^ {a[14:8], 1'b0}) + 8'h5A;
    endfunction

    always @(posedge clk) begin
        if (mem_rd) begin mem_rdata <= pat(mem_addr); n_rd <= n_rd + 1; end
        if (mem_wr) begin
            wl_a[n_wr & 7] <= mem_addr;
            wl_d[n_wr & 7] <= mem_wdata;
            n_wr <= n_wr + 1;
        end
        if (stat_wr) begin last_st <= stat_wdata; n_st <= n_st + 1; end
        if (wel_set) n_set <= n_set + 1;
        if (wel_clr) n_clr <= n_clr + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s mode%0d actual=%0h expected=%0h", tag, mode, act, exp);
        end
    endtask

    task automatic sel();
        spi_sck = mode[0];
        tick(4);
        spi_cs_n = 1'b0;
        tick(H);
    endtask

    task automatic desel();
        tick(H);
        spi_sck = mode[0];
        tick(H);
        spi_cs_n = 1'b1;
        tick(2 * H);
    endtask

    task automatic xb(input logic [7:0] b, input int nb = 8);
        rx = 8'h0; oe_any = 0; oe_all = 1;
        for (int i = 0; i < nb; i++) begin
            spi_si  = b[7-i];
            spi_sck = 1'b0;
            tick(H);
            rx = {rx[6:0], spi_so};
            oe_any |= spi_so_oe;
            oe_all &= spi_so_oe;
            spi_sck = 1'b1;
            tick(H);
        end
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        chk("R9 reset oe", int'(spi_so_oe), 0);
        chk("R2 reset strobes", int'({mem_wr, mem_rd, stat_wr, wel_set, wel_clr}), 0);

        for (int m = 0; m < 2; m++) begin
            int b0, b1, b2, b3;
            mode = m * 3;

            // R1 latch opcodes
            b0 = n_set; sel(); xb(8'h06); desel();
            chk("R1/R13 set pulse", n_set - b0, 1);
            b0 = n_clr; sel(); xb(8'h04); desel();
            chk("R1 clr pulse", n_clr - b0, 1);

            // R2 aborted opcode
            b0 = n_set; b1 = n_clr; sel(); xb(8'h06, 5); desel();
            chk("R2 no set", n_set - b0, 0);
            chk("R2 no clr", n_clr - b1, 0);

            // R3 R4 read with top bit set, wrap, SI toggling
            sel(); xb(8'h03); chk("R9 opcode hiz", int'(oe_any), 0);
            xb(8'hFF); xb(8'hFE); chk("R9 addr hiz", int'(oe_any), 0);
            for (int k = 0; k < 4; k++) begin
                xb(k[0] ? 8'hFF : 8'h00);
                chk("R4/R3 read byte", rx, pat(15'(15'h7FFE + k)));
                chk("R9 oe in data", int'(oe_all), 1);
            end
            desel();
            chk("R9 deselect hiz", int'(spi_so_oe), 0);

            // R4 sweep of start addresses
            for (int s = 0; s < 8; s++) begin
                logic [14:0] a = 15'(s * 4099 + 7);
                sel(); xb(8'h03); xb({1'b0, a[14:8]}); xb(a[7:0]);
                xb(8'hA5);
                chk("R4 sweep", rx, pat(a));
                desel();
            end

            // R5 fast read
            sel(); xb(8'h0B); xb(8'h12); xb(8'h34);
            xb(8'h00); chk("R5 dummy hiz", int'(oe_any), 0);
            for (int k = 0; k < 3; k++) begin
                xb(8'h00);
                chk("R5 fast byte", rx, pat(15'(15'h1234 + k)));
            end
            desel();

            // R7 status loop over a sweep of values
            for (int j = 0; j < 6; j++) begin
                stat_in = 8'(j * 8'h2B + 8'h84);
                sel(); xb(8'h05);
                for (int k = 0; k < 3; k++) begin
                    xb(8'h00);
                    chk("R7 status repeat", rx, int'(stat_in));
                end
                desel();
            end

            // R8 identity
            sel(); xb(8'h9F);
            xb(8'h00); chk("R8 id0", rx, 8'h04);
            xb(8'h00); chk("R8 id1", rx, 8'h7F);
            xb(8'h00); chk("R8 id2", rx, 8'h05);
            xb(8'h00); chk("R8 id3", rx, 8'h09);
            xb(8'h00); chk("R8 hold last bit", rx, 8'hFF);
            desel();

            // R6 R11 write with wrap
            wlim = 16'h8000;
            b0 = n_wr; b1 = n_clr;
            sel(); xb(8'h02); xb(8'hFF); xb(8'hFF);
            for (int k = 0; k < 3; k++) xb(8'(8'h30 + k));
            desel();
            chk("R6 write count", n_wr - b0, 3);
            for (int k = 0; k < 3; k++) begin
                chk("R6 write addr", int'(wl_a[(b0 + k) & 7]), int'(15'(15'h7FFF + k)));
                chk("R6 write data", int'(wl_d[(b0 + k) & 7]), 8'h30 + k);
            end
            chk("R11 clr after write", n_clr - b1, 1);

            // R6 dropped bytes without grant
            wlim = 16'h0010;
            b0 = n_wr;
            sel(); xb(8'h02); xb(8'h00); xb(8'h0E);
            for (int k = 0; k < 3; k++) xb(8'hC0);
            desel();
            chk("R6 granted only", n_wr - b0, 2);
            chk("R6 last granted addr", int'(wl_a[(b0 + 1) & 7]), 15'h000F);
            wlim = 16'h8000;

            // R10 R11 status write
            stat_grant = 1'b1;
            b0 = n_st; b1 = n_clr;
            sel(); xb(8'h01); xb(8'hFF); xb(8'h00); desel();
            chk("R10 one status write", n_st - b0, 1);
            chk("R10 low bits cleared", int'(last_st), 8'hFC);
            chk("R11 clr after status", n_clr - b1, 1);
            stat_grant = 1'b0;
            b0 = n_st;
            sel(); xb(8'h01); xb(8'h55); desel();
            chk("R10 no grant no write", n_st - b0, 0);

            // R12 unknown opcode
            b0 = n_rd; b1 = n_wr; b2 = n_set; b3 = n_clr;
            sel(); xb(8'h5A);
            for (int k = 0; k < 3; k++) begin
                xb(8'h03);
                chk("R12 stays hiz", int'(oe_any), 0);
            end
            desel();
            chk("R12 no access", (n_rd - b0) + (n_wr - b1), 0);
            chk("R12 no pulses", (n_set - b2) + (n_clr - b3), 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule